// File: doc/BRIEF.md
# Audio Sample Pacing Timer

This block paces the output of an audio coprocessor so that samples reach the DAC at exactly regular intervals. A clock prescaler with a selectable division feeds an 8-bit down-counter. Each time the counter expires it produces a strobe. The strobe raises an interrupt request and moves the sample that is waiting into the DAC output register.

The coprocessor's interrupt handler computes the next sample and writes it over the CPU bus. Any write whose top address bit is set lands in a pending register. That value reaches the DAC only at the following strobe. Because of this, the handler's run time has no effect on output timing, provided the handler finishes within one period. The interrupt stays raised until the handler acknowledges it.

Top module: `aud_tick_pacer`

## Requirements
- R1: After reset, `dac_o` is 0x80, `irq_o` is low and the down-counter is zero, so the first prescaler tick after `en_i` goes high produces a strobe.
- R2: With the enable high, strobes repeat every (`reload_i`+1) prescaler ticks. The counter reloads from `reload_i` on the tick after it reaches zero.
- R3: `presc_sel_i` value s gives one prescaler tick every 2^s clock cycles (s = 0..3), so the strobe period is (`reload_i`+1)·2^s cycles.
- R4: A cycle with `wr_en_i` high and `addr_i[15]` high loads `wdata_i` into the pending sample, whatever the other address bits are. A write with `addr_i[15]` low is ignored.
- R5: `dac_o` changes only on the clock edge of a strobe, where it takes the pending value held before that edge. A write captured on the same edge as a strobe is output at the following strobe.
- R6: If no sample is written during a period, `dac_o` keeps its value at the next strobe.
- R7: `irq_o` rises on the edge after a strobe and stays high until an `irq_ack_i` pulse. A strobe on the same edge as an acknowledge leaves it high.
- R8: While `en_i` is low no tick and no strobe occur, and `dac_o` does not change, even if samples are written.
- R9: When several samples are written in one period, the last one is output at the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Runs the prescaler and counter |
| presc_sel_i | input | 2 | Prescaler division select, divide by 2^s |
| reload_i | input | 8 | Counter reload value; the period is reload+1 ticks |
| wr_en_i | input | 1 | CPU write strobe |
| addr_i | input | 16 | CPU write address; only bit 15 is decoded |
| wdata_i | input | 8 | CPU write data |
| irq_ack_i | input | 1 | Clears the interrupt request |
| irq_o | output | 1 | Sample interrupt request |
| dac_o | output | 8 | Sample presented to the DAC |

## Verification
The hardest case to reach is a sample write that lands on the same clock edge as a strobe. That write must skip the current transfer and appear one period later. The driver tracks strobes through the monitor's strobe count, waits period minus one falling edges, and then places the write so that it is captured exactly on the next strobe edge. This is repeated under several prescaler settings, including a reload of zero. The held-interrupt case needs the automatic acknowledge turned off, so that several strobes pass while the request is already high.

// File: rtl/aud_pacer_pkg.sv
package aud_pacer_pkg;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cpu_wr_t;

  localparam logic [DATA_W-1:0] DAC_MID = {1'b1, {(DATA_W-1){1'b0}}};

endpackage

// File: rtl/aud_presc.sv
module aud_presc #(
  parameter int unsigned STAGES = 4,
  localparam int unsigned SEL_W = $clog2(STAGES),
  localparam int unsigned CW    = STAGES - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  logic [CW-1:0]     cnt_q;
  logic [STAGES-1:0] tick_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign tick_vec[0] = en_i;
  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    assign tick_vec[s] = en_i & (&cnt_q[s-1:0]);
  end

  assign tick_o = tick_vec[sel_i];

endmodule

// File: rtl/aud_down_cnt.sv
module aud_down_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             strobe_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero  = (cnt_q == '0);
  assign strobe_o = tick_i & at_zero;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (tick_i)  cnt_q <= at_zero ? reload_i : cnt_q - 1'b1;
  end

endmodule

// File: rtl/aud_sample_buf.sv
module aud_sample_buf
  import aud_pacer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cpu_wr_t           wr_i,
  input  logic              strobe_i,
  output logic [DATA_W-1:0] pend_o,
  output logic [DATA_W-1:0] dac_o
);

  logic [DATA_W-1:0] pend_q, dac_q;
  logic              hit;

  // only the top address bit is decoded
  assign hit = wr_i.en & wr_i.addr[ADDR_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  pend_q <= DAC_MID;
    else if (hit) pend_q <= wr_i.data;
  end

  // pending value from before this edge moves out; a same-edge write waits a period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dac_q <= DAC_MID;
    else if (strobe_i) dac_q <= pend_q;
  end

  assign pend_o = pend_q;
  assign dac_o  = dac_q;

endmodule

// File: rtl/aud_tick_pacer.sv
module aud_tick_pacer
  import aud_pacer_pkg::*;
#(
  parameter int unsigned CNT_W        = 8,
  parameter int unsigned PRESC_STAGES = 4,
  localparam int unsigned SEL_W       = $clog2(PRESC_STAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [SEL_W-1:0]  presc_sel_i,
  input  logic [CNT_W-1:0]  reload_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              irq_ack_i,
  output logic              irq_o,
  output logic [DATA_W-1:0] dac_o
);

  logic              tick;
  logic              strobe;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] pend_q;
  logic              irq_q;
  cpu_wr_t           wr;

  assign wr = '{en: wr_en_i, addr: addr_i, data: wdata_i};

  aud_presc #(.STAGES(PRESC_STAGES)) u_presc (
    .clk_i, .rst_ni, .en_i, .sel_i(presc_sel_i), .tick_o(tick)
  );

  aud_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .reload_i, .cnt_o(cnt_q), .strobe_o(strobe)
  );

  aud_sample_buf u_buf (
    .clk_i, .rst_ni, .wr_i(wr), .strobe_i(strobe), .pend_o(pend_q), .dac_o
  );

  // set has priority over acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (strobe)    irq_q <= 1'b1;
    else if (irq_ack_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/aud_tick_pacer_chk.sv
module aud_tick_pacer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [CNT_W-1:0] reload_i,
  input logic             irq_ack_i,
  input logic             wr_en_i,
  input logic [15:0]      addr_i,
  input logic [7:0]       wdata_i,
  input logic             irq_o,
  input logic [7:0]       dac_o,
  input logic             tick,
  input logic             strobe,
  input logic [CNT_W-1:0] cnt_q,
  input logic [7:0]       pend_q
);

  AST_CNT_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe |=> cnt_q == $past(reload_i)); // R2

  AST_PEND_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[15]) |=> pend_q == $past(wdata_i)); // R4

  AST_PEND_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i[15]) |=> $stable(pend_q)); // R4

  AST_DAC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe |=> $stable(dac_o)); // R5

  AST_DAC_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe |=> dac_o == $past(pend_q)); // R5

  AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe |=> irq_o); // R7

  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> irq_o); // R7

  AST_NO_TICK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !tick && !strobe); // R8

endmodule

bind aud_tick_pacer aud_tick_pacer_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/aud_tick_pacer_tb_top.sv
module aud_tick_pacer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [7:0]  reload = 8'd3;
  logic        wr_en = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        mon_ack = 1'b0;
  logic        man_ack = 1'b0;
  logic        irq;
  logic [7:0]  dac;

  always #4 clk = ~clk;

  aud_tick_pacer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .presc_sel_i(sel), .reload_i(reload),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .irq_ack_i(mon_ack | man_ack),
    .irq_o(irq), .dac_o(dac)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  bit auto_ack = 0;
  bit have_last = 0;
  int exp_per = 4;
  int cyc = 0, last_cyc = 0;
  int strobe_cnt = 0, drv_seen = 0;
  bit irq_prev = 0;
  logic [7:0] exp_q[$];
  logic [7:0] model_pend = 8'h80;

  task automatic check(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // monitor: strobe detection, period and scoreboard compare, auto acknowledge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (irq && !irq_prev) begin
        if (have_last) check(cyc - last_cyc == exp_per, "R2 R3 period", cyc - last_cyc, exp_per);
        last_cyc  = cyc;
        have_last = 1;
        if (exp_q.size() > 0) begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(dac == e, "R5 R6 R9 dac at strobe", dac, e);
        end
        strobe_cnt++;
      end
      irq_prev = irq;
      mon_ack <= auto_ack && irq;
    end
  end

  task automatic cpu_wr(logic [15:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
  endtask

  // driver: one period; nwr writes (last wins), hi selects addr bit 15, late lands on next strobe edge
  task automatic drive_period(int nwr, logic [7:0] v, bit hi, bit late);
    wait (strobe_cnt != drv_seen);
    drv_seen = strobe_cnt;
    if (late) begin
      exp_q.push_back(model_pend);
      repeat (exp_per - 1) @(negedge clk);
      cpu_wr(16'h8000 | 16'h0123, v);
      model_pend = v;
      @(negedge clk);
      wr_en = 1'b0;
    end else begin
      for (int i = 0; i < nwr; i++) begin
        logic [7:0] d;
        d = (i == nwr - 1) ? v : v ^ 8'h5A;
        cpu_wr(hi ? (16'h8000 | 16'(i * 16'h0111)) : 16'h7FF0, d);
        if (hi) model_pend = d;
        @(negedge clk);
      end
      wr_en = 1'b0;
      exp_q.push_back(model_pend);
    end
  endtask

  task automatic start_phase(logic [1:0] s, logic [7:0] r);
    wait (strobe_cnt != drv_seen);
    drv_seen = strobe_cnt;
    @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);
    exp_q.delete();
    sel = s; reload = r;
    exp_per = (int'(r) + 1) << s;
    have_last = 0;
    exp_q.push_back(model_pend);
    drv_seen = strobe_cnt;
    en = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(dac == 8'h80, "R1 reset dac", dac, 8'h80);
    check(irq == 1'b0, "R1 reset irq", irq, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(irq == 1'b0, "R8 no strobe while disabled", irq, 0);
    en = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R1 first tick strobes", irq, 1);
    check(dac == 8'h80, "R1 dac mid after first strobe", dac, 8'h80);
    repeat (10) @(negedge clk);
    check(irq == 1'b1, "R7 irq held without ack", irq, 1);
    en = 1'b0;
    @(negedge clk);
    man_ack = 1'b1;
    @(negedge clk);
    man_ack = 1'b0;
    check(irq == 1'b0, "R7 ack clears irq", irq, 0);
    cpu_wr(16'hC000, 8'h11);
    model_pend = 8'h11;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (40) @(negedge clk);
    check(irq == 1'b0, "R8 no irq while disabled", irq, 0);
    check(dac == 8'h80, "R8 dac unchanged while disabled", dac, 8'h80);
    irq_prev = irq;

    // phase A: divide by 1, period 4
    auto_ack = 1;
    exp_q.push_back(model_pend);
    exp_per = 4; have_last = 0;
    drv_seen = strobe_cnt;
    en = 1'b1;
    drive_period(1, 8'h3C, 1, 0);  // R4
    drive_period(0, 8'h00, 1, 0);  // R6
    drive_period(1, 8'h55, 0, 0);  // R4 low address ignored
    drive_period(2, 8'h07, 1, 0);  // R9
    drive_period(0, 8'hE4, 1, 1);  // R5 same-edge write
    drive_period(0, 8'h00, 1, 0);  // R5 late value appears

    // phase B: divide by 4, reload 2 -> 12 cycles
    start_phase(2'd2, 8'd2);
    drive_period(1, 8'h9B, 1, 0);
    drive_period(0, 8'h00, 1, 0);
    drive_period(0, 8'h00, 1, 0);

    // phase C: divide by 8, reload 0 -> 8 cycles
    start_phase(2'd3, 8'd0);
    drive_period(1, 8'h01, 1, 0);
    drive_period(0, 8'hFE, 1, 1);
    drive_period(0, 8'h00, 1, 0);
    drive_period(0, 8'h00, 1, 0);

    // phase D: divide by 2, reload 5 -> 12 cycles
    start_phase(2'd1, 8'd5);
    drive_period(3, 8'hC3, 1, 0);
    drive_period(0, 8'h00, 1, 0);
    drive_period(0, 8'h00, 1, 0);
    wait (strobe_cnt != drv_seen);
    @(negedge clk);
    check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule